// File: doc/BRIEF.md
# Eight-Entry Label Match Filter

This block decides, word by word, whether a received data word should be handed on to the rest of a serial receiver or quietly discarded. It does this by comparing the word's label byte with a small table of stored label values. A host loads the table over a byte-wide data port. The same port can read the table back.

Loading and readback are one-shot sequences. When a control level is raised, it arms a pointer at entry 0. The following data-port accesses then walk the table, one entry per access. After the last entry the sequence disarms, and further accesses leave the table alone. Filtering, loading and readback exist only while the hardware feature-select pin is high. With the pin low, the control levels are ignored and every word is accepted.

A label that matches nothing produces no pass pulse. The block has no error output, so a mismatch never shows up as an error. The number of entries and the label width are parameters. Their defaults are eight entries of eight bits.

Top module: `label_match_filter`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `word_pass` is 0 and `rd_data` is 0, and every table entry reads back as 0.
- R2: Suppose `feat_sel` and `cfg_lbl_en` are both high in a cycle and the product `feat_sel & cfg_lbl_en` was low in the cycle before. Then the next eight cycles with `host_wr` high store `host_wdata` into entries 0, 1, … 7, in that order.
- R3: Once the eighth of those writes has happened, further `host_wr` strobes leave every entry unchanged until the load sequence is armed again.
- R4: Suppose `feat_sel & cfg_readback` goes from 0 to 1. Then the next eight cycles with `host_rd` high return entries 0 to 7, in order, on `rd_data`. Each value appears in the cycle after its strobe.
- R5: `rd_data` changes only in the cycle after a `host_rd` strobe taken during an armed readback. Reads after the eighth, and reads with no sequence armed, leave it unchanged.
- R6: While `feat_sel` is low, `cfg_lbl_en` has no effect. No load sequence is armed, and every `rx_lbl_vld` produces a `word_pass` pulse whatever the label.
- R7: While `feat_sel` and `cfg_lbl_en` are both high, a strobe on `rx_lbl_vld` produces `word_pass` high in the next cycle when `rx_lbl` equals at least one stored entry. Duplicate entries behave like a single one.
- R8: While filtering, a label equal to no entry produces no `word_pass` pulse and no other output change.
- R9: If `feat_sel` rises while `cfg_lbl_en` is already high, a new eight-write load sequence is armed, and the table can be reloaded.
- R10: While `feat_sel` is low, a rising edge on `cfg_readback` arms no readback sequence.
- R11: `word_pass` is high only in a cycle that directly follows a cycle with `rx_lbl_vld` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| feat_sel | input | 1 | Hardware feature select; high makes filtering available |
| cfg_lbl_en | input | 1 | Control level: enable filtering; its rise arms table loading |
| cfg_readback | input | 1 | Control level: its rise arms table readback |
| host_wr | input | 1 | Data-port write strobe, one cycle per access |
| host_wdata | input | 8 | Data-port write byte |
| host_rd | input | 1 | Data-port read strobe, one cycle per access |
| rd_data | output | 8 | Readback byte, registered |
| rx_lbl | input | 8 | Label byte of the received word |
| rx_lbl_vld | input | 1 | Strobe: `rx_lbl` holds a new label |
| word_pass | output | 1 | One-cycle pulse: the word is accepted |

## Verification
The match path is tested with labels equal to the first entry, equal to the last entry, and equal to an entry that appears twice in the table. These tests show that every comparator slot takes part and that duplicate entries do no harm. Labels that differ from every entry by a single bit show whether the comparison covers the full width. The same labels are sent again with the feature pin low, which separates "filtered" from "accepted anyway". Reads and writes past the eighth access, and arming attempts with the pin low, show whether the one-shot sequencing stops where it should.

// File: rtl/lbl_pkg.sv
package lbl_pkg;
   localparam int LBL_DEF_DEPTH = 8;
   localparam int LBL_DEF_WIDTH = 8;

   typedef enum logic {
      SEQ_IDLE  = 1'b0,
      SEQ_ARMED = 1'b1
   } seq_state_e;
endpackage

// File: rtl/lbl_oneshot.sv
module lbl_oneshot
   import lbl_pkg::*;
#(
   parameter  int DEPTH = LBL_DEF_DEPTH,
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          trig_lvl,
   input  logic          step,
   output logic          armed,
   output logic [PW-1:0] ptr
);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   seq_state_e st_q;
   logic       trig_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= SEQ_IDLE;
         trig_q <= 1'b0;
         ptr    <= '0;
      end else begin
         trig_q <= trig_lvl;
         if (trig_lvl && !trig_q) begin
            st_q <= SEQ_ARMED;
            ptr  <= '0;
         end else if (step && st_q == SEQ_ARMED) begin
            if (ptr == LAST) begin
               st_q <= SEQ_IDLE;
               ptr  <= '0;
            end else begin
               ptr <= ptr + 1'b1;
            end
         end
      end
   end

   assign armed = (st_q == SEQ_ARMED);
endmodule

// File: rtl/lbl_store.sv
module lbl_store
   import lbl_pkg::*;
#(
   parameter  int DEPTH = LBL_DEF_DEPTH,
   parameter  int WIDTH = LBL_DEF_WIDTH,
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   we,
   input  logic [PW-1:0]          wptr,
   input  logic [WIDTH-1:0]       wdata,
   output logic [DEPTH*WIDTH-1:0] tbl_flat
);
   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
      logic [WIDTH-1:0] ent_q;
      always_ff @(posedge clk) begin
         if (rst)
            ent_q <= '0;
         else if (we && wptr == PW'(gi))
            ent_q <= wdata;
      end
      assign tbl_flat[gi*WIDTH +: WIDTH] = ent_q;
   end
endmodule

// File: rtl/lbl_match.sv
module lbl_match
   import lbl_pkg::*;
#(
   parameter int DEPTH = LBL_DEF_DEPTH,
   parameter int WIDTH = LBL_DEF_WIDTH
) (
   input  logic [DEPTH*WIDTH-1:0] tbl_flat,
   input  logic [WIDTH-1:0]       probe,
   output logic                   hit
);
   logic [DEPTH-1:0] hit_vec;

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
      assign hit_vec[gi] = (tbl_flat[gi*WIDTH +: WIDTH] == probe);
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/label_match_filter.sv
module label_match_filter
   import lbl_pkg::*;
#(
   parameter  int DEPTH = LBL_DEF_DEPTH,
   parameter  int WIDTH = LBL_DEF_WIDTH,
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             feat_sel,
   input  logic             cfg_lbl_en,
   input  logic             cfg_readback,
   input  logic             host_wr,
   input  logic [WIDTH-1:0] host_wdata,
   input  logic             host_rd,
   output logic [WIDTH-1:0] rd_data,
   input  logic [WIDTH-1:0] rx_lbl,
   input  logic             rx_lbl_vld,
   output logic             word_pass
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("label_match_filter: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("label_match_filter: WIDTH must be at least 1");
   end

   logic                   filt_on;
   logic                   rb_trig;
   logic                   ld_armed;
   logic                   rb_armed;
   logic [PW-1:0]          ld_ptr;
   logic [PW-1:0]          rb_ptr;
   logic [DEPTH*WIDTH-1:0] tbl_flat;
   logic                   hit;

   assign filt_on = feat_sel & cfg_lbl_en;
   assign rb_trig = feat_sel & cfg_readback;

   lbl_oneshot #(.DEPTH(DEPTH)) u_ld_seq (
      .clk     (clk),
      .rst     (rst),
      .trig_lvl(filt_on),
      .step    (host_wr),
      .armed   (ld_armed),
      .ptr     (ld_ptr)
   );

   lbl_oneshot #(.DEPTH(DEPTH)) u_rb_seq (
      .clk     (clk),
      .rst     (rst),
      .trig_lvl(rb_trig),
      .step    (host_rd),
      .armed   (rb_armed),
      .ptr     (rb_ptr)
   );

   lbl_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
      .clk     (clk),
      .rst     (rst),
      .we      (host_wr & ld_armed),
      .wptr    (ld_ptr),
      .wdata   (host_wdata),
      .tbl_flat(tbl_flat)
   );

   lbl_match #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_match (
      .tbl_flat(tbl_flat),
      .probe   (rx_lbl),
      .hit     (hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data   <= '0;
         word_pass <= 1'b0;
      end else begin
         if (host_rd && rb_armed)
            rd_data <= tbl_flat[rb_ptr*WIDTH +: WIDTH];
         word_pass <= rx_lbl_vld & (~filt_on | hit);
      end
   end
endmodule

// File: rtl/lbl_filter_chk.sv
module lbl_filter_chk #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 8
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   feat_sel,
   input logic                   cfg_lbl_en,
   input logic                   host_rd,
   input logic [WIDTH-1:0]       rd_data,
   input logic                   rx_lbl_vld,
   input logic                   word_pass,
   input logic                   ld_armed,
   input logic [DEPTH*WIDTH-1:0] tbl_flat
);
   AST_PASS_AFTER_VLD: assert property (@(posedge clk) disable iff (rst)
      word_pass |-> $past(rx_lbl_vld)); // R11

   AST_UNFILTERED_PASS: assert property (@(posedge clk) disable iff (rst)
      (rx_lbl_vld && !(feat_sel && cfg_lbl_en)) |=> word_pass); // R6

   AST_NO_ARM_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
      (!feat_sel && !ld_armed) |=> !ld_armed); // R6

   AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !ld_armed |=> $stable(tbl_flat)); // R3

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
      !host_rd |=> $stable(rd_data)); // R5
endmodule

bind label_match_filter lbl_filter_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .feat_sel  (feat_sel),
   .cfg_lbl_en(cfg_lbl_en),
   .host_rd   (host_rd),
   .rd_data   (rd_data),
   .rx_lbl_vld(rx_lbl_vld),
   .word_pass (word_pass),
   .ld_armed  (ld_armed),
   .tbl_flat  (tbl_flat)
);

// File: tb/label_match_filter_bench.sv
`timescale 1ns/1ps
module label_match_filter_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       feat_sel = 1'b0;
   logic       cfg_lbl_en = 1'b0;
   logic       cfg_readback = 1'b0;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic       host_rd = 1'b0;
   logic [7:0] rd_data;
   logic [7:0] rx_lbl = '0;
   logic       rx_lbl_vld = 1'b0;
   logic       word_pass;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] tblA [8];
   logic [7:0] tblB [8];

   always #2.5 clk = ~clk;

   label_match_filter u_label_match_filter (
      .clk(clk), .rst(rst), .feat_sel(feat_sel), .cfg_lbl_en(cfg_lbl_en),
      .cfg_readback(cfg_readback), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .rd_data(rd_data), .rx_lbl(rx_lbl),
      .rx_lbl_vld(rx_lbl_vld), .word_pass(word_pass)
   );

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_byte(logic [7:0] b);
      @(negedge clk); host_wr = 1'b1; host_wdata = b;
      @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic rd_byte(output logic [7:0] b);
      @(negedge clk); host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0; b = rd_data;
   endtask

   // Level change, then one clock edge for the arming edge to register.
   task automatic set_lvl(logic fs, logic en, logic rb);
      @(negedge clk); feat_sel = fs; cfg_lbl_en = en; cfg_readback = rb;
   endtask

   task automatic send_lbl(string req, logic [7:0] l, logic exp);
      @(negedge clk); rx_lbl = l; rx_lbl_vld = 1'b1;
      @(negedge clk); rx_lbl_vld = 1'b0;
      chk(req, {7'd0, word_pass}, {7'd0, exp});
      @(negedge clk);
      chk("R11 pulse ends", {7'd0, word_pass}, 8'd0);
   endtask

   task automatic readback_all(string req, logic [7:0] exp [8]);
      logic [7:0] b;
      logic fs, en;
      fs = feat_sel; en = cfg_lbl_en;
      set_lvl(fs, en, 1'b0);
      set_lvl(fs, en, 1'b1);
      for (int i = 0; i < 8; i++) begin
         rd_byte(b);
         chk(req, b, exp[i]);
      end
      set_lvl(fs, en, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1 word_pass in reset", {7'd0, word_pass}, 8'd0);
      chk("R1 rd_data in reset", rd_data, 8'd0);
      @(negedge clk); rst = 1'b0;
      chk("R1 word_pass after reset", {7'd0, word_pass}, 8'd0);
      chk("R1 rd_data after reset", rd_data, 8'd0);
      set_lvl(1'b1, 1'b0, 1'b0);
      readback_all("R1 entry zero", '{default: 8'h00});
   endtask

   task automatic t_load_read();
      set_lvl(1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) wr_byte(tblA[i]);
      readback_all("R2/R4 readback order", tblA);
   endtask

   task automatic t_one_shot();
      logic [7:0] b;
      wr_byte(8'hEE);
      readback_all("R3 ninth write ignored", tblA);
      rd_byte(b);
      chk("R5 ninth read holds", b, tblA[7]);
   endtask

   task automatic t_match();
      send_lbl("R7 first entry", tblA[0], 1'b1);
      send_lbl("R7 last entry", tblA[7], 1'b1);
      send_lbl("R7 middle entry", tblA[3], 1'b1);
      send_lbl("R8 no match", 8'h00, 1'b0);
      send_lbl("R8 one bit off", tblA[5] ^ 8'h80, 1'b0);
      send_lbl("R8 one bit off low", tblA[2] ^ 8'h01, 1'b0);
   endtask

   task automatic t_pin_low();
      logic [7:0] b;
      set_lvl(1'b0, 1'b0, 1'b0);
      set_lvl(1'b0, 1'b1, 1'b0);
      wr_byte(8'h55);
      send_lbl("R6 unfiltered pass", 8'h00, 1'b1);
      send_lbl("R6 unfiltered pass 2", tblA[5] ^ 8'h80, 1'b1);
      set_lvl(1'b0, 1'b1, 1'b1);
      rd_byte(b);
      chk("R10 no readback pin low", b, tblA[7]);
      set_lvl(1'b0, 1'b0, 1'b0);
      set_lvl(1'b1, 1'b0, 1'b0);
      readback_all("R6 no load pin low", tblA);
   endtask

   task automatic t_rearm();
      set_lvl(1'b0, 1'b1, 1'b0);
      set_lvl(1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) wr_byte(tblB[i]);
      readback_all("R9 reload on pin rise", tblB);
      send_lbl("R7 duplicate entry", 8'h2A, 1'b1);
      send_lbl("R8 old label dropped", tblA[0], 1'b0);
   endtask

   initial begin
      #500000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) tblA[i] = 8'h13 + 8'(i * 29);
      tblB = '{8'h2A, 8'h2A, 8'h2A, 8'h91, 8'h91, 8'h07, 8'h07, 8'h2A};
      repeat (3) @(negedge clk);
      t_reset();
      t_load_read();
      t_one_shot();
      t_match();
      t_pin_low();
      t_rearm();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule